// File: doc/BRIEF.md
# SMM-Aware Shadow RAM Decoder

This block sits beside the host memory path and classifies every host memory cycle in the first megabyte. A cycle that targets the upper BIOS window (C0000h to FFFFFh) is steered either to shadow DRAM or to the ISA bus. The choice depends on a per-segment, per-direction enable bit. Cycles below C0000h always go to DRAM. Cycles at or above 1 MiB are left alone: neither route is claimed.

Two enable sets exist. The normal set covers the C0000h window in four 16 KiB slices, plus whole 64 KiB segments at D0000h, E0000h and F0000h. The second set applies only while the CPU runs system management code, and it covers only D0000h, E0000h and F0000h. The set is picked separately for each cycle, from the active-low management-mode input captured on the cycle-start strobe. As a result, one address can reach DRAM in one mode and ISA in the other. The physical DRAM address does not depend on the mode.

The three enable registers are reached through an index/data byte port. The route decision is registered on the cycle-start strobe. It is then held until the host signals that the cycle is done.

Top module: `shadow_smm_decoder`

## Requirements
- R1: After reset, all three enable registers read 00h, `route_valid` is low, and every cycle in C0000h-FFFFFh is routed to ISA in both modes.
- R2: A port write with `cfg_sel`=0 loads the index. A port write with `cfg_sel`=1 writes the register selected by the index: 19h is normal read enables, 1Ah is normal write enables, 1Ch is management enables. `cfg_rdata` always shows the register at the current index. Any other index reads 00h and ignores writes.
- R3: Reserved bits read as zero. That is bit 7 of registers 19h and 1Ah, and bits 3 and 7 of register 1Ch.
- R4: In normal mode, reads use register 19h and writes use register 1Ah. Bits 0-3 enable the C0000h slices selected by address bits 15:14. Bits 4, 5 and 6 enable D0000h, E0000h and F0000h. A set bit routes the cycle to DRAM; a clear bit routes it to ISA.
- R5: In management mode (`smm_act_n` low at the strobe), the D0000h, E0000h and F0000h segments use register 1Ch instead. Bits 0, 1 and 2 are the write enables for those segments, and bits 4, 5 and 6 are the read enables. With 1Ch = 77h, the whole D0000h-FFFFFh range is read/write DRAM.
- R6: In management mode, the C0000h slices keep using the normal-mode bits of 19h and 1Ah.
- R7: Any address below C0000h routes to DRAM, whatever the mode and the register contents.
- R8: An address at or above 100000h asserts neither `route_dram` nor `route_isa`.
- R9: The mode, direction and address are taken at the accepted `cyc_start`. The route then stays fixed until `cyc_done`, even if `smm_act_n` or any register changes in the meantime.
- R10: `dram_addr` equals address bits 19:0 of the accepted cycle, in either mode.
- R11: A `cyc_start` that arrives while a cycle is open is ignored.
- R12: The outputs `route_dram` and `route_isa` are never high together, and both are low while `route_valid` is low. The route appears one clock after the strobe. `route_valid` drops one clock after `cyc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Config port write strobe |
| cfg_sel | input | 1 | 0 = index register, 1 = data register |
| cfg_wdata | input | 8 | Config write byte |
| cfg_rdata | output | 8 | Register at the current index |
| cyc_start | input | 1 | Host cycle start strobe |
| cyc_done | input | 1 | Host cycle completion |
| cyc_addr | input | ADDR_W | Host byte address |
| cyc_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| smm_act_n | input | 1 | Management mode active, low true |
| route_valid | output | 1 | A decoded cycle is open |
| route_dram | output | 1 | Cycle goes to shadow or main DRAM |
| route_isa | output | 1 | Cycle goes to the ISA bus |
| route_smm | output | 1 | Mode captured for the open cycle |
| dram_addr | output | 20 | DRAM byte address, mode independent |

## Verification
The bench builds the block with its default 24-bit address. This lets it place cycles both inside the first megabyte and just above it, at 100000h and 1E0000h, where the decoder must stay silent. Every C0000h slice and each of the three upper segments is swept in both directions and both modes, against several enable patterns. Separate cycles change the mode input and the management register in the middle of an open cycle, and issue a second strobe while a cycle is still open.

// File: rtl/shadow_dec_pkg.sv
// Shared constants and types for the shadow RAM decoder.
// Assumes an 8-bit configuration port.
package shadow_dec_pkg;
    localparam int          CFG_W      = 8;
    localparam logic [7:0]  IDX_USR_RD = 8'h19;
    localparam logic [7:0]  IDX_USR_WR = 8'h1A;
    localparam logic [7:0]  IDX_SMM    = 8'h1C;
    localparam logic [7:0]  USR_MASK   = 8'h7F;
    localparam logic [7:0]  SMM_MASK   = 8'h77;
    localparam int          NUM_SEG    = 4;   // C, D, E, F segments

    typedef struct packed {
        logic [CFG_W-1:0] usr_rd;
        logic [CFG_W-1:0] usr_wr;
        logic [CFG_W-1:0] smm;
    } shadow_cfg_t;
endpackage

// File: rtl/shadow_cfg_port.sv
// Index/data configuration port holding the three enable registers.
// Assumes single-cycle write strobes. Reserved bits are never stored,
// so they read back as zero. Unknown indices read zero and drop writes.
module shadow_cfg_port
    import shadow_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output shadow_cfg_t       cfg_o
);
    logic [CFG_W-1:0] idx_q;
    shadow_cfg_t      regs_q;

    // Index register and enable registers, written through the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            regs_q <= '0;
        end else if (cfg_wr) begin
            if (!cfg_sel) begin
                idx_q <= cfg_wdata;
            end else begin
                case (idx_q)
                    IDX_USR_RD: regs_q.usr_rd <= cfg_wdata & USR_MASK;
                    IDX_USR_WR: regs_q.usr_wr <= cfg_wdata & USR_MASK;
                    IDX_SMM:    regs_q.smm    <= cfg_wdata & SMM_MASK;
                    default:    ;
                endcase
            end
        end
    end

    // Read mux for the currently indexed register.
    always_comb begin
        case (idx_q)
            IDX_USR_RD: cfg_rdata = regs_q.usr_rd;
            IDX_USR_WR: cfg_rdata = regs_q.usr_wr;
            IDX_SMM:    cfg_rdata = regs_q.smm;
            default:    cfg_rdata = '0;
        endcase
    end

    assign cfg_o = regs_q;

    // R2: a data write never moves the index.
    p_index_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel) |=> $stable(idx_q));
endmodule

// File: rtl/shadow_seg_lut.sv
// Combinational route lookup for one host address.
// Assumes byte addresses of ADDR_W > 20 bits. Only the first MiB is decoded.
module shadow_seg_lut
    import shadow_dec_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              smm,
    input  shadow_cfg_t       cfg,
    output logic              hit_dram,
    output logic              hit_isa
);
    localparam int SEG_W = $clog2(NUM_SEG);

    logic             in_mib;
    logic             upper;
    logic [SEG_W-1:0] seg;
    logic [1:0]       slice;
    logic [CFG_W-1:0] usr_bits;
    logic [NUM_SEG-1:0] usr_en;
    logic [NUM_SEG-1:0] smm_en;
    logic             en;

    assign in_mib   = ~|addr[ADDR_W-1:20];
    assign upper    = (addr[19:18] == 2'b11);
    assign seg      = addr[17:16];
    assign slice    = addr[15:14];
    assign usr_bits = wr ? cfg.usr_wr : cfg.usr_rd;

    // The C segment is sliced and has no management bits of its own.
    assign usr_en[0] = usr_bits[slice];
    assign smm_en[0] = usr_bits[slice];

    // Per-segment enables for D, E and F in both modes.
    for (genvar g = 1; g < NUM_SEG; g++) begin : g_seg
        assign usr_en[g] = usr_bits[g + 3];
        assign smm_en[g] = wr ? cfg.smm[g - 1] : cfg.smm[g + 3];
    end

    // Pick the enable set for this cycle.
    always_comb begin
        en = smm ? smm_en[seg] : usr_en[seg];
    end

    assign hit_dram = in_mib & (~upper | en);
    assign hit_isa  = in_mib & upper & ~en;
endmodule

// File: rtl/shadow_smm_decoder.sv
// Top level: captures each host cycle on its start strobe, decodes it,
// and holds the route until the host signals completion.
// Assumes cyc_done is only asserted for an open cycle.
module shadow_smm_decoder
    import shadow_dec_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              cyc_start,
    input  logic              cyc_done,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_wr,
    input  logic              smm_act_n,
    output logic              route_valid,
    output logic              route_dram,
    output logic              route_isa,
    output logic              route_smm,
    output logic [19:0]       dram_addr
);
    shadow_cfg_t cfg;
    logic        lut_dram;
    logic        lut_isa;
    logic        accept;
    logic        busy_q, dram_q, isa_q, smm_q, hi_q;
    logic [19:0] addr_q;

    shadow_cfg_port u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_o     (cfg)
    );

    shadow_seg_lut #(.ADDR_W(ADDR_W)) u_lut (
        .addr     (cyc_addr),
        .wr       (cyc_wr),
        .smm      (~smm_act_n),
        .cfg      (cfg),
        .hit_dram (lut_dram),
        .hit_isa  (lut_isa)
    );

    assign accept = cyc_start & ~busy_q;

    // Capture the decision at the strobe and keep it until completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            dram_q <= 1'b0;
            isa_q  <= 1'b0;
            smm_q  <= 1'b0;
            hi_q   <= 1'b0;
            addr_q <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            dram_q <= lut_dram;
            isa_q  <= lut_isa;
            smm_q  <= ~smm_act_n;
            hi_q   <= |cyc_addr[ADDR_W-1:20];
            addr_q <= cyc_addr[19:0];
        end else if (busy_q && cyc_done) begin
            busy_q <= 1'b0;
            dram_q <= 1'b0;
            isa_q  <= 1'b0;
        end
    end

    assign route_valid = busy_q;
    assign route_dram  = dram_q;
    assign route_isa   = isa_q;
    assign route_smm   = smm_q;
    assign dram_addr   = addr_q;

    // R12: the two routes exclude each other and are quiet when idle.
    p_route_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(route_dram && route_isa) && (route_valid || (!route_dram && !route_isa)));

    // R9: an open cycle keeps its decision until done.
    p_route_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (route_valid && !cyc_done) |=> (route_valid && $stable(route_dram)
                                        && $stable(route_isa) && $stable(route_smm)));

    // R7: low memory always lands in DRAM.
    p_low_dram_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (route_valid && !hi_q && dram_addr[19:18] != 2'b11) |-> route_dram);

    // R8: above 1 MiB nothing is claimed.
    p_above_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (route_valid && hi_q) |-> (!route_dram && !route_isa));

    // R11: a strobe during an open cycle leaves the address alone.
    p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (route_valid && cyc_start && !cyc_done) |=> $stable(dram_addr));
endmodule

// File: tb/shadow_smm_decoder_bench.sv
// Scoreboard bench: the driver queues expected routes, the monitor checks them.
module shadow_smm_decoder_bench;
    localparam int AW = 24;

    typedef struct {
        logic        dram;
        logic        isa;
        logic [19:0] addr;
        string       req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic          cyc_start = 1'b0, cyc_done = 1'b0, cyc_wr = 1'b0;
    logic          smm_act_n = 1'b1;
    logic [AW-1:0] cyc_addr = '0;
    logic          route_valid, route_dram, route_isa, route_smm;
    logic [19:0]   dram_addr;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;
    exp_t sb[$];
    logic [7:0] m_ur = '0, m_uw = '0, m_sm = '0;
    logic prev_valid = 1'b0;

    always #2 clk = ~clk;

    shadow_smm_decoder u_shadow_smm_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cyc_start(cyc_start),
        .cyc_done(cyc_done), .cyc_addr(cyc_addr), .cyc_wr(cyc_wr),
        .smm_act_n(smm_act_n), .route_valid(route_valid), .route_dram(route_dram),
        .route_isa(route_isa), .route_smm(route_smm), .dram_addr(dram_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected route from the requirements: {dram, isa}.
    function automatic logic [1:0] model(logic [AW-1:0] a, logic w, logic s);
        int   seg;
        logic [7:0] ub;
        logic en;
        if (a[AW-1:20] != 0) return 2'b00;
        if (a[19:18] != 2'b11) return 2'b10;
        seg = int'(a[17:16]);
        ub  = w ? m_uw : m_ur;
        if (s && seg != 0) en = w ? m_sm[seg-1] : m_sm[seg+3];
        else if (seg == 0) en = ub[a[15:14]];
        else en = ub[seg+3];
        return en ? 2'b10 : 2'b01;
    endfunction

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] val);
        @(negedge clk); cfg_wr = 1; cfg_sel = 0; cfg_wdata = idx;
        @(negedge clk); cfg_sel = 1; cfg_wdata = val;
        @(negedge clk); cfg_wr = 0;
        if (idx == 8'h19) m_ur = val & 8'h7F;
        if (idx == 8'h1A) m_uw = val & 8'h7F;
        if (idx == 8'h1C) m_sm = val & 8'h77;
    endtask

    task automatic cfg_check(input logic [7:0] idx, input logic [7:0] exp, input string req);
        @(negedge clk); cfg_wr = 1; cfg_sel = 0; cfg_wdata = idx;
        @(negedge clk); cfg_wr = 0;
        chk(cfg_rdata == exp, req, cfg_rdata, exp);
    endtask

    // mode 0 plain, 1 disturb mid-cycle (R9), 2 second strobe while busy (R11)
    task automatic run_cyc(input logic [AW-1:0] a, input logic w, input logic s,
                           input int mode, input string req);
        exp_t e;
        logic [1:0] r;
        logic d0, i0;
        r = model(a, w, s);
        e.dram = r[1]; e.isa = r[0]; e.addr = a[19:0]; e.req = req;
        sb.push_back(e);
        @(negedge clk); cyc_start = 1; cyc_addr = a; cyc_wr = w; smm_act_n = ~s;
        @(negedge clk); cyc_start = 0;
        d0 = route_dram; i0 = route_isa;
        if (mode == 1) begin
            smm_act_n = s;
            cfg_write(8'h1C, ~m_sm);
            cfg_write(8'h19, ~m_ur);
            chk(route_dram == d0 && route_isa == i0 && route_smm == s, "R9",
                {route_dram, route_isa}, {d0, i0});
        end
        if (mode == 2) begin
            cyc_start = 1; cyc_addr = a ^ 24'h00_4000; cyc_wr = ~w;
            @(negedge clk); cyc_start = 0;
            @(negedge clk);
            chk(dram_addr == a[19:0] && route_dram == d0, "R11", dram_addr, a[19:0]);
        end
        cyc_done = 1;
        @(negedge clk); cyc_done = 0;
        @(negedge clk);
        chk(!route_valid && !route_dram && !route_isa, "R12", route_valid, 0);
    endtask

    // Monitor: pop and compare on the first idle-to-open edge of each cycle.
    always @(negedge clk) begin
        if (rst_n && route_valid && !prev_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R12 unexpected cycle", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(route_dram == e.dram && route_isa == e.isa, e.req,
                    {route_dram, route_isa}, {e.dram, e.isa});
                chk(dram_addr == e.addr, "R10", dram_addr, e.addr);
            end
        end
        prev_valid <= route_valid;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(route_valid == 0, "R1", route_valid, 0);
        cfg_check(8'h19, 8'h00, "R1");
        cfg_check(8'h1A, 8'h00, "R1");
        cfg_check(8'h1C, 8'h00, "R1");
        run_cyc(24'h0D_1234, 0, 0, 0, "R1");
        run_cyc(24'h0F_0010, 1, 1, 0, "R1");

        // R2 / R3 register port behaviour
        cfg_write(8'h19, 8'h0F); cfg_check(8'h19, 8'h0F, "R2");
        cfg_write(8'h1B, 8'hFF); cfg_check(8'h1B, 8'h00, "R2");
        cfg_check(8'h19, 8'h0F, "R2");
        cfg_write(8'h1C, 8'hFF); cfg_check(8'h1C, 8'h77, "R3");
        cfg_write(8'h1A, 8'hFF); cfg_check(8'h1A, 8'h7F, "R3");

        // R4 / R5 / R6 sweeps over several enable patterns
        for (int p = 0; p < 3; p++) begin
            cfg_write(8'h19, p == 0 ? 8'h55 : (p == 1 ? 8'h2A : 8'h00));
            cfg_write(8'h1A, p == 0 ? 8'h2A : (p == 1 ? 8'h55 : 8'h7F));
            cfg_write(8'h1C, p == 0 ? 8'h25 : (p == 1 ? 8'h52 : 8'h77));
            for (int sg = 0; sg < 7; sg++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int s = 0; s < 2; s++) begin
                        logic [AW-1:0] a;
                        a = (sg < 4) ? (24'h0C_0000 + sg * 24'h4000 + 24'h0123)
                                     : (24'h0D_0000 + (sg - 4) * 24'h1_0000 + 24'h0456);
                        run_cyc(a, w[0], s[0], 0,
                                sg < 4 ? (s ? "R6" : "R4") : (s ? "R5" : "R4"));
                    end
                end
            end
        end

        // R7 low memory, R8 above 1 MiB
        cfg_write(8'h19, 8'h00); cfg_write(8'h1A, 8'h00); cfg_write(8'h1C, 8'h00);
        run_cyc(24'h03_8000, 0, 1, 0, "R7");
        run_cyc(24'h0B_FFFF, 1, 0, 0, "R7");
        run_cyc(24'h10_0000, 0, 0, 0, "R8");
        run_cyc(24'h1E_0000, 1, 1, 0, "R8");

        // R9 disturbance mid-cycle, R11 strobe while busy
        cfg_write(8'h1C, 8'h70);
        run_cyc(24'h0E_8000, 0, 1, 1, "R9");
        run_cyc(24'h0E_8000, 1, 0, 1, "R9");
        run_cyc(24'h0C_4000, 0, 0, 2, "R11");
        run_cyc(24'h0F_F000, 1, 1, 2, "R11");

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R12 pending", sb.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule